// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink that records a stream of 32-bit trace words into an on-chip RAM used as a ring. A producer presents words with a valid strobe and may pulse a trigger input. Software controls the block over a simple register bus that has an address, write and read strobes, write data and combinational read data.

Words are captured only while capture is enabled and the block has not stopped. Capture stops in one of two ways. In the first, a programmable number of words is stored after a trigger and then capture halts. In the second, a manual flush request completes and capture halts. Once the write pointer has wrapped, a sticky full flag marks the ring as full, and the oldest word then sits at the write pointer. Software can read the ring through an auto-incrementing read port. It can also load or clear the ring through an auto-incrementing write port.

Register offsets (12-bit byte address): 0x004 depth, 0x00C status, 0x010 ring read data, 0x014 read pointer, 0x018 write pointer, 0x01C post-trigger count, 0x020 control, 0x024 ring write data, 0x300 flush status, 0x304 flush control.

Top module: `trcbuf_top`

## Requirements
- R1: Offset 0x004 reads the parameter DEPTH (default 256). Writes to it have no effect.
- R2: After reset, the following read 0: read pointer, write pointer, status, control, flush control and post-trigger count. Flush status reads 2, meaning bit 1 (stopped) is set and bit 0 (flush busy) is clear.
- R3: A write to 0x024 stores the data at the write pointer and advances the pointer, modulo DEPTH. When the pointer advances from DEPTH-1 to 0, status bit 0 (full) is set. A write to 0x018 loads the write pointer and clears status bit 0.
- R4: A read strobe at 0x010 returns the word at the read pointer and advances the pointer, modulo DEPTH. A write to 0x014 loads the read pointer. Pointers read back zero-extended.
- R5: A trace word is stored at the write pointer, which then advances, only in a cycle where all of the following hold: control bit 0 (capture enable) is 1, valid is 1, the block is not stopped, and software is not writing 0x018 or 0x024 in the same cycle.
- R6: Status bit 0 stays set across further wraps. When it is set, the oldest stored word is at the write pointer, so a readout of DEPTH words starting there returns the words in arrival order.
- R7: A trigger pulse seen while capturing sets status bit 1 and loads the count from 0x01C. If flush-control bit 13 (stop on trigger) is set, exactly that many further words are stored and capture then stops. The word that arrives with the trigger is also stored.
- R8: Writing 1 to flush-control bit 6 starts a flush. Bit 6 reads 1 for FLUSH_LAT cycles and then clears itself. If flush-control bit 12 (stop on flush) is set when the flush completes, capture stops. Flush-control bits 0, 12 and 13 read back as written.
- R9: Flush-status bit 1 reads 1 whenever capture is not active, which means either capture enable is 0 or the block has stopped. Flush-status bit 0 mirrors a flush in progress.
- R10: Any write to 0x020 clears the stopped condition and status bit 1, so capture can resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances read pointer at 0x010) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger pulse |

## Verification
Wrong internal state shows up at the pointers, which can be read back directly. A store that was missed or added moves the write pointer one place away from the count the bench expects, and this is visible on the next register read. It also shifts every word of a later readout. A full flag in the wrong state sends the readout to the wrong starting word, so the oldest-first sequence is visibly rotated. A trigger countdown or flush that ends one cycle early or late changes the number of words stored after the stop, which can be read from the write pointer as soon as the stream ends.

// File: rtl/trcbuf_pkg.sv
// Shared register offsets and flush-control bit positions for the trace buffer.
package trcbuf_pkg;
    localparam logic [11:0] A_DEPTH = 12'h004;
    localparam logic [11:0] A_STAT  = 12'h00C;
    localparam logic [11:0] A_RDATA = 12'h010;
    localparam logic [11:0] A_RPTR  = 12'h014;
    localparam logic [11:0] A_WPTR  = 12'h018;
    localparam logic [11:0] A_TRIG  = 12'h01C;
    localparam logic [11:0] A_CTRL  = 12'h020;
    localparam logic [11:0] A_WDATA = 12'h024;
    localparam logic [11:0] A_FSTAT = 12'h300;
    localparam logic [11:0] A_FCTRL = 12'h304;

    localparam int FC_FMT    = 0;
    localparam int FC_FLUSH  = 6;
    localparam int FC_STOPFL = 12;
    localparam int FC_STOPTR = 13;
endpackage

// File: rtl/trcbuf_ram.sv
// Ring storage: one synchronous write port and one combinational read port.
// Assumes DEPTH is a power of two; contents are not reset.
module trcbuf_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Word at the read address.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/trcbuf_ptrs.sv
// Read and write pointers with sticky wrap flag. Software loads take
// priority over advances; loading the write pointer clears the flag.
module trcbuf_ptrs #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_load,
    input  logic [AW-1:0] wp_val,
    input  logic          wp_adv,
    input  logic          rp_load,
    input  logic [AW-1:0] rp_val,
    input  logic          rp_adv,
    output logic [AW-1:0] wp,
    output logic [AW-1:0] rp,
    output logic          full
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Write pointer and sticky full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            full <= 1'b0;
        end else if (wp_load) begin
            wp   <= wp_val;
            full <= 1'b0;
        end else if (wp_adv) begin
            wp <= wp + 1'b1;
            if (wp == LAST) full <= 1'b1;
        end
    end

    // Read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)       rp <= '0;
        else if (rp_load) rp <= rp_val;
        else if (rp_adv)  rp <= rp + 1'b1;
    end
endmodule

// File: rtl/trcbuf_capctl.sv
// Capture control: enable, post-trigger countdown, manual flush and the
// stopped condition. Decides which trace words are stored.
module trcbuf_capctl #(
    parameter int TW        = 16,
    parameter int FLUSH_LAT = 4,
    localparam int FCW      = $clog2(FLUSH_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          ctrl_val,
    input  logic          fctl_we,
    input  logic          fctl_fmt,
    input  logic          fctl_flush,
    input  logic          fctl_stopfl,
    input  logic          fctl_stoptr,
    input  logic          trg_we,
    input  logic [TW-1:0] trg_val,
    input  logic          trc_valid,
    input  logic          trc_trigger,
    input  logic          sw_ram_busy,
    output logic          cap_en,
    output logic          store,
    output logic          stopped,
    output logic          halted,
    output logic          trig_seen,
    output logic          flush_busy,
    output logic          fmt_en,
    output logic          stop_flush,
    output logic          stop_trig,
    output logic [TW-1:0] trg_cnt
);
    logic [TW-1:0]  remain_q;
    logic [FCW-1:0] fcnt_q;
    logic           trig_done;
    logic           active;
    logic           flush_done;

    assign trig_done  = trig_seen && (remain_q == '0) && stop_trig;
    assign active     = cap_en && !halted && !trig_done;
    assign store      = active && trc_valid && !sw_ram_busy;
    assign stopped    = !active;
    assign flush_done = flush_busy && (fcnt_q == FCW'(1));

    // Enable, halt and trigger countdown state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en    <= 1'b0;
            halted    <= 1'b0;
            trig_seen <= 1'b0;
            remain_q  <= '0;
        end else if (ctrl_we) begin
            cap_en    <= ctrl_val;
            halted    <= 1'b0;
            trig_seen <= 1'b0;
            remain_q  <= '0;
        end else begin
            if (cap_en && trig_done)        halted <= 1'b1;
            if (flush_done && stop_flush)   halted <= 1'b1;
            if (active && trc_trigger && !trig_seen) begin
                trig_seen <= 1'b1;
                remain_q  <= trg_cnt;
            end else if (store && trig_seen && remain_q != '0) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Self-clearing manual flush sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_busy <= 1'b0;
            fcnt_q     <= '0;
        end else if (fctl_we && fctl_flush && !flush_busy) begin
            flush_busy <= 1'b1;
            fcnt_q     <= FCW'(FLUSH_LAT);
        end else if (flush_busy) begin
            fcnt_q <= fcnt_q - 1'b1;
            if (flush_done) flush_busy <= 1'b0;
        end
    end

    // Flush-control mode bits and post-trigger count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_en     <= 1'b0;
            stop_flush <= 1'b0;
            stop_trig  <= 1'b0;
            trg_cnt    <= '0;
        end else begin
            if (fctl_we) begin
                fmt_en     <= fctl_fmt;
                stop_flush <= fctl_stopfl;
                stop_trig  <= fctl_stoptr;
            end
            if (trg_we) trg_cnt <= trg_val;
        end
    end
endmodule

// File: rtl/trcbuf_top.sv
// Circular trace capture buffer: register decode, read mux and the glue
// between the ring, its pointers and the capture controller.
// Assumes DEPTH is a power of two and at most 2**31.
module trcbuf_top #(
    parameter int DEPTH     = 256,
    parameter int TW        = 16,
    parameter int FLUSH_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        trc_valid,
    input  logic [31:0] trc_data,
    input  logic        trc_trigger
);
    import trcbuf_pkg::*;
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wp_q, rp_q;
    logic          full_q;
    logic [31:0]   ram_rdata, ram_wdata;
    logic          ram_we;
    logic          sw_wdata, sw_wptr, sw_ram_busy, rd_adv;
    logic          cap_en, store, stopped, halted, trig_seen;
    logic          flush_busy, fmt_en, stop_flush, stop_trig;
    logic [TW-1:0] trg_cnt;

    assign sw_wdata    = reg_wr && (reg_addr == A_WDATA);
    assign sw_wptr     = reg_wr && (reg_addr == A_WPTR);
    assign sw_ram_busy = sw_wdata || sw_wptr;
    assign rd_adv      = reg_rd && (reg_addr == A_RDATA);
    assign ram_we      = sw_wdata || store;
    assign ram_wdata   = sw_wdata ? reg_wdata : trc_data;

    trcbuf_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wp_q),
        .wdata (ram_wdata),
        .raddr (rp_q),
        .rdata (ram_rdata)
    );

    trcbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_load (sw_wptr),
        .wp_val  (reg_wdata[AW-1:0]),
        .wp_adv  (ram_we),
        .rp_load (reg_wr && (reg_addr == A_RPTR)),
        .rp_val  (reg_wdata[AW-1:0]),
        .rp_adv  (rd_adv),
        .wp      (wp_q),
        .rp      (rp_q),
        .full    (full_q)
    );

    trcbuf_capctl #(.TW(TW), .FLUSH_LAT(FLUSH_LAT)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (reg_wr && (reg_addr == A_CTRL)),
        .ctrl_val    (reg_wdata[0]),
        .fctl_we     (reg_wr && (reg_addr == A_FCTRL)),
        .fctl_fmt    (reg_wdata[FC_FMT]),
        .fctl_flush  (reg_wdata[FC_FLUSH]),
        .fctl_stopfl (reg_wdata[FC_STOPFL]),
        .fctl_stoptr (reg_wdata[FC_STOPTR]),
        .trg_we      (reg_wr && (reg_addr == A_TRIG)),
        .trg_val     (reg_wdata[TW-1:0]),
        .trc_valid   (trc_valid),
        .trc_trigger (trc_trigger),
        .sw_ram_busy (sw_ram_busy),
        .cap_en      (cap_en),
        .store       (store),
        .stopped     (stopped),
        .halted      (halted),
        .trig_seen   (trig_seen),
        .flush_busy  (flush_busy),
        .fmt_en      (fmt_en),
        .stop_flush  (stop_flush),
        .stop_trig   (stop_trig),
        .trg_cnt     (trg_cnt)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_DEPTH: reg_rdata = 32'(DEPTH);
            A_STAT:  reg_rdata = {30'd0, trig_seen, full_q};
            A_RDATA: reg_rdata = ram_rdata;
            A_RPTR:  reg_rdata = 32'(rp_q);
            A_WPTR:  reg_rdata = 32'(wp_q);
            A_TRIG:  reg_rdata = 32'(trg_cnt);
            A_CTRL:  reg_rdata = {31'd0, cap_en};
            A_FSTAT: reg_rdata = {30'd0, stopped, flush_busy};
            A_FCTRL: begin
                reg_rdata[FC_FMT]    = fmt_en;
                reg_rdata[FC_FLUSH]  = flush_busy;
                reg_rdata[FC_STOPFL] = stop_flush;
                reg_rdata[FC_STOPTR] = stop_trig;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trcbuf_chk.sv
// Protocol checker for the trace buffer, attached by bind.
module trcbuf_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [11:0]   reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp,
    input logic          full,
    input logic          cap_en,
    input logic          halted,
    input logic          stopped,
    input logic          flush_busy,
    input logic          stop_flush
);
    import trcbuf_pkg::*;

    p_wptr_clears_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_WPTR) |=> !full);

    p_read_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RDATA && !reg_wr) |=> (rp == AW'($past(rp) + 1'b1)));

    p_no_store_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !reg_wr) |=> $stable(wp));

    p_no_store_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !reg_wr) |=> $stable(wp));

    p_flush_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flush_busy) && stop_flush && !$past(reg_wr)) |-> stopped);
endmodule

bind trcbuf_top trcbuf_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .wp         (wp_q),
    .rp         (rp_q),
    .full       (full_q),
    .cap_en     (cap_en),
    .halted     (halted),
    .stopped    (stopped),
    .flush_busy (flush_busy),
    .stop_flush (stop_flush)
);

// File: tb/trcbuf_top_tb_top.sv
`timescale 1ns/1ps
module trcbuf_top_tb_top;
    localparam int DEPTH = 256;
    localparam int FLUSH_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trc_valid = 1'b0, trc_trigger = 1'b0;
    logic [31:0] trc_data = '0;

    int errors = 0, checks = 0;
    logic [31:0] mdl_mem [DEPTH];
    int mdl_wp = 0;
    bit mdl_full = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trcbuf_top #(.DEPTH(DEPTH), .FLUSH_LAT(FLUSH_LAT)) dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, bit adv, output logic [31:0] d);
        reg_addr = a; reg_rd = adv;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int next_ptr(int p);
        return (p + 1) % DEPTH;
    endfunction

    // Model one stored word.
    task automatic mdl_store(logic [31:0] d);
        mdl_mem[mdl_wp] = d;
        if (mdl_wp == DEPTH - 1) mdl_full = 1;
        mdl_wp = next_ptr(mdl_wp);
    endtask

    task automatic clear_ring();
        wr(12'h018, 0);
        for (int i = 0; i < DEPTH; i++) begin
            wr(12'h024, 32'h0);
            mdl_mem[i] = 32'h0;
        end
        mdl_wp = 0;
        mdl_full = 1;
    endtask

    // Capture a random stream of n cycles, then disable and read it back.
    task automatic random_run(int n, string tag);
        logic [31:0] v;
        int start, cnt, bad;
        wr(12'h018, 0); mdl_wp = 0; mdl_full = 0;
        wr(12'h020, 1);
        for (int i = 0; i < n; i++) begin
            trc_valid = $urandom_range(0, 1);
            trc_data  = $urandom;
            if (trc_valid) mdl_store(trc_data);
            @(negedge clk);
        end
        trc_valid = 1'b0;
        wr(12'h020, 0);
        rd(12'h018, 0, v); check({"R5 wp after ", tag}, v, mdl_wp);
        rd(12'h00C, 0, v); check({"R6 full after ", tag}, v & 1, 32'(mdl_full));
        start = mdl_full ? mdl_wp : 0;
        cnt   = mdl_full ? DEPTH : mdl_wp;
        wr(12'h014, start);
        bad = 0;
        for (int i = 0; i < cnt; i++) begin
            rd(12'h010, 1, v);
            if (v !== mdl_mem[(start + i) % DEPTH]) bad++;
        end
        check({"R6 readout mismatches ", tag}, bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(12'h014, 0, v); check("R2 rp", v, 0);
        rd(12'h018, 0, v); check("R2 wp", v, 0);
        rd(12'h00C, 0, v); check("R2 status", v, 0);
        rd(12'h020, 0, v); check("R2 ctrl", v, 0);
        rd(12'h304, 0, v); check("R2 fctrl", v, 0);
        rd(12'h01C, 0, v); check("R2 trig", v, 0);
        rd(12'h300, 0, v); check("R2 fstat", v, 2);

        // R1 depth constant, writes ignored
        wr(12'h004, 32'h5);
        rd(12'h004, 0, v); check("R1 depth", v, DEPTH);

        // R5 trace ignored while disabled
        trc_valid = 1'b1; trc_data = 32'hDEAD; idle(5); trc_valid = 1'b0;
        rd(12'h018, 0, v); check("R5 wp disabled", v, 0);

        // R3 clear ring wraps and sets full; pointer write clears it
        clear_ring();
        rd(12'h018, 0, v); check("R3 wp after wrap", v, 0);
        rd(12'h00C, 0, v); check("R3 full set", v & 1, 1);
        wr(12'h018, 0);
        rd(12'h00C, 0, v); check("R3 full cleared", v & 1, 0);
        wr(12'h024, 32'hA5A5_0001); wr(12'h024, 32'hA5A5_0002);
        rd(12'h018, 0, v); check("R3 wp advance", v, 2);

        // R4 read pointer load and wrap
        wr(12'h018, DEPTH - 1); wr(12'h024, 32'h1234_5678);
        wr(12'h014, DEPTH - 1);
        rd(12'h010, 1, v); check("R4 word at last", v, 32'h1234_5678);
        rd(12'h010, 1, v); check("R4 word at 0", v, 32'hA5A5_0001);
        rd(12'h014, 0, v); check("R4 rp wrapped", v, 1);

        // R5 R6 random streams, with and without wrap
        clear_ring();
        random_run(120, "short");
        random_run(700, "wrap");

        // R7 trigger countdown with stop-on-trigger
        wr(12'h018, 0);
        wr(12'h01C, 5);
        wr(12'h304, 32'h2000);
        wr(12'h020, 1);
        for (int i = 0; i < 20; i++) begin
            trc_valid = 1'b1; trc_data = 32'h100 + i;
            trc_trigger = (i == 7);
            @(negedge clk);
        end
        trc_valid = 1'b0; trc_trigger = 1'b0;
        rd(12'h018, 0, v); check("R7 words after trigger", v, 13);
        rd(12'h00C, 0, v); check("R7 trigger seen", v, 2);
        rd(12'h300, 0, v); check("R9 stopped by trigger", v, 2);
        rd(12'h020, 0, v); check("R9 enable still set", v, 1);

        // R10 control write resumes capture
        wr(12'h304, 0);
        wr(12'h020, 1);
        rd(12'h00C, 0, v); check("R10 trigger cleared", v, 0);
        trc_valid = 1'b1; idle(3); trc_valid = 1'b0;
        rd(12'h018, 0, v); check("R10 resumed", v, 16);

        // R8 flush without stop: self-clears, capture continues
        wr(12'h304, 32'h0041);
        rd(12'h304, 0, v); check("R8 flush busy", v, 32'h41);
        idle(FLUSH_LAT + 2);
        rd(12'h304, 0, v); check("R8 flush cleared", v, 32'h1);
        rd(12'h300, 0, v); check("R9 active after flush", v, 0);

        // R8 flush with stop-on-flush halts capture
        wr(12'h304, 32'h1040);
        rd(12'h300, 0, v); check("R9 flush busy status", v & 1, 1);
        idle(FLUSH_LAT + 2);
        rd(12'h300, 0, v); check("R8 stopped after flush", v, 2);
        trc_valid = 1'b1; idle(5); trc_valid = 1'b0;
        rd(12'h018, 0, v); check("R8 no store after flush", v, 16);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule